// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block keeps track of cache-line misses that are still waiting for data from the next memory level, on behalf of one streaming core. Each per-thread load that missed in the first-level cache is presented on the miss input with its thread number and full byte address. The block address is the request address with its low offset bits dropped. If a tracked block with that address is already waiting, the thread is attached to that entry and nothing goes downstream. Otherwise the lowest-numbered idle entry is claimed, and one downstream request carrying the block address and the entry number is sent.

When the next level returns a fill tagged with an entry number, the block walks through every thread attached to that entry, one per cycle, in the order they joined. For each one it emits the thread number, that thread's own offset inside the block, and the fill word. After the last thread it releases the entry. A single downstream request and a single fill therefore serve every thread that touched the same block.

The miss input stalls when no entry can take the thread. A fill input stalls while an earlier fill is still being handed out. An entry whose fill is being handed out no longer accepts new threads, so a later miss to that block claims a fresh entry.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use: req_valid and wb_valid are 0, and miss_ready and fill_ready are 1.
- R2: An accepted miss whose block (miss_addr >> OFF_W) matches no open entry claims the lowest-numbered idle entry. On the next clock it raises req_valid for one cycle with req_block equal to that block and req_id equal to that entry number.
- R3: An accepted miss whose block matches an open entry, one not being drained, joins that entry and produces no downstream request.
- R4: A miss whose block matches an open entry that already holds MERGE threads sees miss_ready at 0 and is not taken.
- R5: A miss whose block matches no open entry while every entry is in use sees miss_ready at 0 and is not taken.
- R6: A fill accepted for entry k produces one writeback per thread attached to k, on consecutive cycles in joining order. Each writeback carries the thread number, that thread's offset (miss_addr[OFF_W-1:0]) and fill_data. The first writeback appears on the second rising edge after the fill is taken.
- R7: fill_ready is 0 from the clock after a fill is taken until its last writeback has been issued.
- R8: An entry is released after its last writeback and can then be claimed again as the lowest idle entry.
- R9: A miss to a block whose entry is being drained, including in the cycle it is released, claims a fresh entry and issues its own downstream request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A per-thread miss is presented |
| miss_ready | output | 1 | The presented miss can be taken this cycle |
| miss_tid | input | TID_W | Thread number of the miss |
| miss_addr | input | ADDR_W | Byte address of the miss |
| req_valid | output | 1 | Downstream block request, one-cycle pulse |
| req_block | output | ADDR_W-OFF_W | Block address requested |
| req_id | output | clog2(ENTRIES) | Entry number to tag the request with |
| fill_valid | input | 1 | A fill returns from the next level |
| fill_ready | output | 1 | A fill can be taken this cycle |
| fill_id | input | clog2(ENTRIES) | Entry number the fill belongs to |
| fill_data | input | DATA_W | Returned data word |
| wb_valid | output | 1 | One per-thread writeback |
| wb_tid | output | TID_W | Thread being written back |
| wb_off | output | OFF_W | That thread's offset inside the block |
| wb_data | output | DATA_W | Data for that thread |

## Verification
The bench builds the table with ENTRIES=4 and MERGE=3 and keeps the 16-bit address, 4-bit offset, 5-bit thread and 32-bit data widths. With four entries, a handful of misses fill the whole table, so the table-full stall and the reuse of a released lowest entry are within reach. With three threads per entry, the per-entry limit stall is reached after three misses to one block. A miss aimed at a block whose fill is being handed out exercises the fresh-allocation rule while the table still has a released slot to give.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Outcome of presenting one miss to the table.
  typedef enum logic [1:0] {
    MK_STALL = 2'd0,
    MK_ALLOC = 2'd1,
    MK_MERGE = 2'd2
  } miss_kind_e;
endpackage

// File: rtl/mshr_lookup.sv
// Fully associative block compare plus lowest-index idle entry pick.
module mshr_lookup #(
  parameter int ENTRIES = 8,
  parameter int BLK_W   = 12,
  parameter int CNT_W   = 3,
  parameter int MERGE   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ENTRIES-1:0] ent_excl,
  input  logic [BLK_W-1:0]   ent_blk [ENTRIES],
  input  logic [CNT_W-1:0]   ent_cnt [ENTRIES],
  input  logic [BLK_W-1:0]   look_blk,
  output logic               hit,
  output logic               hit_full,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [CNT_W-1:0]   hit_cnt,
  output logic               free_any,
  output logic [IDX_W-1:0]   free_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && !ent_excl[g] && (ent_blk[g] == look_blk);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
    hit      = |match;
    hit_cnt  = ent_cnt[hit_idx];
    hit_full = hit && (hit_cnt == CNT_W'(MERGE));
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
    free_any = !(&ent_valid);
  end
endmodule

// File: rtl/mshr_slot_ram.sv
// Simple dual-port storage for per-thread records, registered read.
module mshr_slot_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int MERGE   = 4,
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int TID_W   = 5,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        miss_valid,
  output logic                        miss_ready,
  input  logic [TID_W-1:0]            miss_tid,
  input  logic [ADDR_W-1:0]           miss_addr,
  output logic                        req_valid,
  output logic [ADDR_W-OFF_W-1:0]     req_block,
  output logic [$clog2(ENTRIES)-1:0]  req_id,
  input  logic                        fill_valid,
  output logic                        fill_ready,
  input  logic [$clog2(ENTRIES)-1:0]  fill_id,
  input  logic [DATA_W-1:0]           fill_data,
  output logic                        wb_valid,
  output logic [TID_W-1:0]            wb_tid,
  output logic [OFF_W-1:0]            wb_off,
  output logic [DATA_W-1:0]           wb_data
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(MERGE + 1);
  localparam int DEPTH = ENTRIES * MERGE;
  localparam int AW    = $clog2(DEPTH);
  localparam int REC_W = TID_W + OFF_W;

  // Entry state
  logic [ENTRIES-1:0] ent_valid;
  logic [BLK_W-1:0]   ent_blk [ENTRIES];
  logic [CNT_W-1:0]   ent_cnt [ENTRIES];

  // Drain state
  logic               drain_active;
  logic [IDX_W-1:0]   drain_id;
  logic [CNT_W-1:0]   drain_pos;
  logic [DATA_W-1:0]  drain_data;
  logic [ENTRIES-1:0] drain_mask;
  logic               drain_last;

  // Lookup results
  logic               hit, hit_full, free_any;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic [CNT_W-1:0]   hit_cnt;
  logic [BLK_W-1:0]   look_blk;
  miss_kind_e         kind;
  logic               take_fill;

  // Record store
  logic               rec_we;
  logic [AW-1:0]      rec_waddr, rec_raddr;
  logic [REC_W-1:0]   rec_rdata;

  function automatic logic [AW-1:0] slot_addr(input logic [IDX_W-1:0] idx,
                                              input logic [CNT_W-1:0] pos);
    return AW'(idx) * AW'(MERGE) + AW'(pos);
  endfunction

  assign look_blk = miss_addr[ADDR_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
    assign drain_mask[g] = drain_active && (drain_id == IDX_W'(g));
  end

  mshr_lookup #(
    .ENTRIES(ENTRIES), .BLK_W(BLK_W), .CNT_W(CNT_W), .MERGE(MERGE)
  ) u_lookup (
    .ent_valid(ent_valid), .ent_excl(drain_mask), .ent_blk(ent_blk),
    .ent_cnt(ent_cnt), .look_blk(look_blk), .hit(hit), .hit_full(hit_full),
    .hit_idx(hit_idx), .hit_cnt(hit_cnt), .free_any(free_any), .free_idx(free_idx)
  );

  always_comb begin
    if (hit)           kind = hit_full ? MK_STALL : MK_MERGE;
    else if (free_any) kind = MK_ALLOC;
    else               kind = MK_STALL;
  end

  assign miss_ready = (kind != MK_STALL);
  assign fill_ready = !drain_active;
  assign take_fill  = fill_valid && fill_ready;
  assign drain_last = drain_active && (drain_pos + CNT_W'(1) == ent_cnt[drain_id]);

  assign rec_we    = miss_valid && miss_ready;
  assign rec_waddr = (kind == MK_MERGE) ? slot_addr(hit_idx, hit_cnt)
                                        : slot_addr(free_idx, '0);
  assign rec_raddr = slot_addr(drain_id, drain_pos);

  mshr_slot_ram #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_recs (
    .clk(clk), .we(rec_we), .waddr(rec_waddr),
    .wdata({miss_tid, miss_addr[OFF_W-1:0]}),
    .raddr(rec_raddr), .rdata(rec_rdata)
  );

  assign {wb_tid, wb_off} = rec_rdata;

  // Entry table
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_blk[i] <= '0;
        ent_cnt[i] <= '0;
      end
    end else begin
      if (drain_last) ent_valid[drain_id] <= 1'b0;
      if (miss_valid && kind == MK_MERGE) begin
        ent_cnt[hit_idx] <= hit_cnt + CNT_W'(1);
      end else if (miss_valid && kind == MK_ALLOC) begin
        ent_valid[free_idx] <= 1'b1;
        ent_blk[free_idx]   <= look_blk;
        ent_cnt[free_idx]   <= CNT_W'(1);
      end
    end
  end

  // Downstream request
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_block <= '0;
      req_id    <= '0;
    end else begin
      req_valid <= miss_valid && (kind == MK_ALLOC);
      if (miss_valid && kind == MK_ALLOC) begin
        req_block <= look_blk;
        req_id    <= free_idx;
      end
    end
  end

  // Fill sweep
  always_ff @(posedge clk) begin
    if (rst) begin
      drain_active <= 1'b0;
      drain_id     <= '0;
      drain_pos    <= '0;
      drain_data   <= '0;
      wb_valid     <= 1'b0;
      wb_data      <= '0;
    end else begin
      wb_valid <= drain_active;
      if (drain_active) wb_data <= drain_data;
      if (take_fill) begin
        drain_active <= 1'b1;
        drain_id     <= fill_id;
        drain_pos    <= '0;
        drain_data   <= fill_data;
      end else if (drain_last) begin
        drain_active <= 1'b0;
      end else if (drain_active) begin
        drain_pos <= drain_pos + CNT_W'(1);
      end
    end
  end
endmodule

module mshr_file_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              req_valid,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data
);
  // R1: reset empties the output pulses
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !wb_valid));

  // R2: a request only follows an accepted miss
  assert_req_from_miss_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(miss_valid && miss_ready));

  // R4 / R5: a stalled miss sends nothing downstream
  assert_stall_no_req_R5: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_ready) |=> !req_valid);

  // R6: one fill word is held through a run of writebacks
  assert_wb_data_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && $past(wb_valid)) |-> $stable(wb_data));

  // R7: a taken fill blocks the next one
  assert_fill_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_ready) |=> !fill_ready);
endmodule

bind mshr_file mshr_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .req_valid(req_valid), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  localparam int NE = 4, NM = 3, AW = 16, OW = 4, TW = 5, DW = 32;
  localparam int IW = $clog2(NE);

  logic clk = 1'b0, rst = 1'b1;
  logic miss_valid = 0, miss_ready;
  logic [TW-1:0] miss_tid = '0;
  logic [AW-1:0] miss_addr = '0;
  logic req_valid; logic [AW-OW-1:0] req_block; logic [IW-1:0] req_id;
  logic fill_valid = 0, fill_ready;
  logic [IW-1:0] fill_id = '0;
  logic [DW-1:0] fill_data = '0;
  logic wb_valid; logic [TW-1:0] wb_tid; logic [OW-1:0] wb_off; logic [DW-1:0] wb_data;

  always #4 clk = ~clk;  // 125 MHz

  mshr_file #(.ENTRIES(NE), .MERGE(NM), .ADDR_W(AW), .OFF_W(OW), .TID_W(TW), .DATA_W(DW)) u_mshr_file (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_tid(miss_tid), .miss_addr(miss_addr), .req_valid(req_valid),
    .req_block(req_block), .req_id(req_id), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_id(fill_id), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_off(wb_off), .wb_data(wb_data));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // Expected streams
  logic [AW-OW+IW-1:0] req_q [$];
  logic [TW+OW+DW-1:0] wb_q [$];

  // Reference table
  bit           m_valid [NE];
  bit           m_drain [NE];
  int           m_n     [NE];
  logic [AW-OW-1:0] m_blk [NE];
  logic [TW-1:0] m_tid [NE][NM];
  logic [OW-1:0] m_off [NE][NM];

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (req_q.size() == 0) check(0, "R2 unexpected request", {req_block, req_id}, 0);
      else begin
        logic [AW-OW+IW-1:0] e;
        e = req_q.pop_front();
        check({req_block, req_id} == e, "R2 request block/id", {req_block, req_id}, e);
      end
    end
    if (!rst && wb_valid) begin
      if (wb_q.size() == 0) check(0, "R6 unexpected writeback", {wb_tid, wb_off, wb_data}, 0);
      else begin
        logic [TW+OW+DW-1:0] e;
        e = wb_q.pop_front();
        check({wb_tid, wb_off, wb_data} == e, "R6 writeback tid/off/data", {wb_tid, wb_off, wb_data}, e);
      end
    end
  end

  // Driver: present one miss, check ready against the reference, update it
  task automatic send_miss(input logic [TW-1:0] tid, input logic [AW-1:0] addr, input string tag);
    logic [AW-OW-1:0] blk;
    int hit, fr;
    bit exp_rdy;
    blk = addr[AW-1:OW];
    hit = -1; fr = -1;
    for (int i = 0; i < NE; i++)
      if (m_valid[i] && !m_drain[i] && m_blk[i] == blk) hit = i;
    for (int i = NE - 1; i >= 0; i--)
      if (!m_valid[i]) fr = i;
    exp_rdy = (hit >= 0) ? (m_n[hit] < NM) : (fr >= 0);
    miss_valid = 1; miss_tid = tid; miss_addr = addr;
    #1;
    check(miss_ready == exp_rdy, {tag, " miss_ready"}, miss_ready, exp_rdy);
    if (exp_rdy) begin
      if (hit >= 0) begin
        m_tid[hit][m_n[hit]] = tid; m_off[hit][m_n[hit]] = addr[OW-1:0]; m_n[hit]++;
      end else begin
        m_valid[fr] = 1; m_blk[fr] = blk; m_n[fr] = 1;
        m_tid[fr][0] = tid; m_off[fr][0] = addr[OW-1:0];
        req_q.push_back({blk, IW'(fr)});
      end
    end
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic send_fill(input int id, input logic [DW-1:0] d);
    for (int k = 0; k < m_n[id]; k++) wb_q.push_back({m_tid[id][k], m_off[id][k], d});
    m_drain[id] = 1;
    fill_valid = 1; fill_id = IW'(id); fill_data = d;
    #1;
    check(fill_ready == 1'b1, "R7 fill_ready before fill", fill_ready, 1);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
    check(fill_ready == 1'b0, "R7 fill_ready during sweep", fill_ready, 0);
  endtask

  task automatic wait_drain(input int id);
    while (wb_q.size() != 0) @(negedge clk);
    @(negedge clk);
    m_valid[id] = 0; m_drain[id] = 0; m_n[id] = 0;
    check(fill_ready == 1'b1, "R8 fill_ready after sweep", fill_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_drain[i] = 0; m_n[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(miss_ready == 1, "R1 miss_ready", miss_ready, 1);
    check(fill_ready == 1, "R1 fill_ready", fill_ready, 1);
    check(req_valid == 0, "R1 req_valid", req_valid, 0);
    check(wb_valid == 0, "R1 wb_valid", wb_valid, 0);

    send_miss(5'd1, 16'h0A40, "R2 alloc e0");
    send_miss(5'd2, 16'h0A44, "R3 merge e0");
    send_miss(5'd3, 16'h0A50, "R2 alloc e1");
    send_miss(5'd4, 16'h0A54, "R3 merge e1");
    send_miss(5'd5, 16'h0A48, "R3 third merge e0");
    send_miss(5'd6, 16'h0A4C, "R4 entry full stall");
    send_miss(5'd7, 16'h0B00, "R2 alloc e2");
    send_miss(5'd8, 16'h0C00, "R2 alloc e3");
    send_miss(5'd11, 16'h0D00, "R5 table full stall");
    send_miss(5'd9, 16'h0C04, "R3 merge into full table");
    check(req_q.size() == 0, "R2 requests delivered", req_q.size(), 0);

    send_fill(1, 32'hAAAA_0001);   // R6 two-thread sweep
    wait_drain(1);
    send_miss(5'd10, 16'h0E00, "R8 reuse released e1");
    send_fill(2, 32'hBBBB_0002);
    wait_drain(2);
    send_fill(0, 32'hCCCC_0003);
    send_miss(5'd12, 16'h0A4C, "R9 miss to draining block");
    wait_drain(0);
    send_fill(3, 32'hDDDD_0004);
    wait_drain(3);
    send_fill(1, 32'hEEEE_0005);
    wait_drain(1);
    send_fill(2, 32'hFFFF_0006);   // R9 fresh entry serves its own thread
    wait_drain(2);

    repeat (4) @(negedge clk);
    check(req_q.size() == 0, "R2 no missing request", req_q.size(), 0);
    check(wb_q.size() == 0, "R6 no missing writeback", wb_q.size(), 0);
    check(miss_ready == 1, "R8 table empty again", miss_ready, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule